// File: doc/BRIEF.md
# Absolute Position Frame Transmitter (BiSS C / SSI slave)

This block is the sensor side of a synchronous serial position link. It holds a multiturn period count, a singleturn angle and two error flags, all given as parallel inputs. When the master starts a read by pulling its clock line low, the block takes a snapshot of those values and of its configuration. It then returns one bit on each later rising master clock edge. The reply is an acknowledge and start/control preamble, then the payload, then an inverted CRC. After the last bit the line is held low for a timeout and then released high.

Configuration inputs set the frame. They choose the multiturn field length, the angle resolution and the CRC polynomial. They also choose a fixed short, fixed long or adaptive end-of-frame timeout. A plain SSI mode returns the payload alone, with no preamble and no CRC. The master clock arrives asynchronously and passes through a two-stage synchronizer, so every line update trails its master edge by a fixed number of system clock cycles.

Top module: `biss_pos_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `slo` is 1.
- R2: A falling edge of `ma` while idle captures `pos_mt`, `pos_st`, `err_amp`, `err_freq` and all `cfg_*` inputs. Later input changes have no effect on that frame.
- R3: Each rising edge of `ma` after the capture sends the next frame bit on `slo`, 3 `clk` cycles after the edge reaches the `ma` pin. In BiSS mode (`cfg_ssi`=0) the first three bits are 0 (acknowledge), 1 (start) and 0 (control bit).
- R4: Payload order, each field MSB first: multiturn field, angle field, `err_amp`, `err_freq`.
- R5: `cfg_mt_len` selects the multiturn field as the low bits of `pos_mt`: 0 gives no field, 1 gives 8 bits, 2 gives 12 bits and 3 gives 24 bits.
- R6: The angle field is the top W bits of the 13-bit `pos_st`. W is `cfg_st_bits` clamped to the range 3 to 13.
- R7: With `cfg_mt_len` 0 or 1 the CRC is 5 bits, polynomial x^5+x^2+1. With 2 or 3 it is 6 bits, polynomial x^6+x+1. `cfg_crc6`=1 forces the 6-bit polynomial for any length code.
- R8: The CRC is computed MSB first over the payload bits, starting from zero. It is sent MSB first, with every bit inverted.
- R9: The first rising `ma` edge after the last frame bit drives `slo` to 0. The line then stays 0 for N `clk` cycles and returns to 1. N is 46 with `cfg_short_tmo`=0 and 3 with `cfg_short_tmo`=1.
- R10: With `cfg_adapt_tmo`=1, N is instead the `clk`-cycle distance between the last two rising `ma` edges of the frame, saturated at 255.
- R11: `ma` edges during the timeout are ignored. They neither change the timeout length nor start a new frame.
- R12: With `cfg_ssi`=1 the payload starts at the first rising edge, with no preamble bits and no CRC. The timeout follows the last payload bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ma | input | 1 | Master clock line, asynchronous, idles high |
| pos_mt | input | 24 | Multiturn period count |
| pos_st | input | 13 | Singleturn angle |
| err_amp | input | 1 | Amplitude error flag (first error bit) |
| err_freq | input | 1 | Frequency error flag (second error bit) |
| cfg_mt_len | input | 2 | Multiturn length code |
| cfg_st_bits | input | 4 | Angle resolution in bits |
| cfg_crc6 | input | 1 | Force the 6-bit CRC polynomial |
| cfg_short_tmo | input | 1 | Select the short fixed timeout |
| cfg_adapt_tmo | input | 1 | Use the measured master clock period as timeout |
| cfg_ssi | input | 1 | SSI mode: no preamble, no CRC |
| slo | output | 1 | Slave data line |

## Verification
The assertions assume that `ma` stays stable for more than three `clk` cycles between edges. Each edge must pass through the synchronizer before the next one arrives, and the period measurement and frame sequencing rely on that spacing. The stimulus drives `ma` only on falling `clk` edges, with half periods of four to six cycles. It returns `ma` high at the end of each frame and lets the timeout expire before the next capture. The only exception is the deliberate pulse placed inside a long timeout.

// File: rtl/biss_tx_pkg.sv
// Package: shared constants, state type and field helpers for the position
// frame transmitter. Assumes the multiturn length codes are fixed at 0/8/12/24.
package biss_tx_pkg;

    localparam int MT_MAX_W  = 24;
    localparam int ST_MAX_W  = 13;
    localparam int ST_MIN_W  = 3;
    localparam int CRC_MAX_W = 6;
    localparam int PL_MAX_W  = MT_MAX_W + ST_MAX_W + 2;
    localparam int LEN_W     = $clog2(PL_MAX_W + 1);

    // Low-order taps of the two generator polynomials (leading term implied).
    localparam logic [5:0] TAPS_CRC6 = 6'h03;   // x^6 + x + 1
    localparam logic [5:0] TAPS_CRC5 = 6'h05;   // x^5 + x^2 + 1

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_WAIT,
        TX_HDR,
        TX_DATA,
        TX_CRC,
        TX_TMO
    } tx_state_t;

    // Multiturn field width for a length code.
    function automatic logic [4:0] mt_width(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd8;
            2'd2:    return 5'd12;
            default: return 5'd24;
        endcase
    endfunction

    // Angle width clamped to the legal range.
    function automatic logic [3:0] st_width(input logic [3:0] req);
        if (req < 4'(ST_MIN_W))
            return 4'(ST_MIN_W);
        if (req > 4'(ST_MAX_W))
            return 4'(ST_MAX_W);
        return req;
    endfunction

endpackage

// File: rtl/biss_ma_sync.sv
// Master clock synchronizer and edge detector.
// Brings the asynchronous master clock into the clk domain with two flops,
// flags single-cycle rising and falling events, and measures the rise-to-rise
// distance in clk cycles. Assumes the line idles high and that edges are
// spaced wider than the synchronizer latency.
module biss_ma_sync #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ma_in,
    output logic             ma_rise,
    output logic             ma_fall,
    output logic [PER_W-1:0] period_now
);

    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    logic             s1, s2, s_d;
    logic [PER_W-1:0] per_cnt;

    // Two-stage synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            s_d <= 1'b1;
        end else begin
            s1  <= ma_in;
            s2  <= s1;
            s_d <= s2;
        end
    end

    assign ma_rise = s2 & ~s_d;
    assign ma_fall = ~s2 & s_d;

    // Cycle counter restarted by each rising event, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_cnt <= '0;
        else if (ma_rise)
            per_cnt <= '0;
        else if (per_cnt != PER_MAX)
            per_cnt <= per_cnt + 1'b1;
    end

    // Distance from the previous rise to the current cycle, inclusive.
    assign period_now = (per_cnt == PER_MAX) ? PER_MAX : per_cnt + 1'b1;

    a_r10_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ma_rise |-> (period_now != '0));

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ma_rise |=> !ma_rise);

endmodule

// File: rtl/biss_payload_fmt.sv
// Payload formatter (combinational).
// Packs the captured multiturn field, angle field and the two error bits into
// a right-justified word and reports its length and CRC width choice.
// Assumes the inputs are held stable for the whole frame by the caller.
module biss_payload_fmt
    import biss_tx_pkg::*;
(
    input  logic [1:0]          mt_code,
    input  logic [3:0]          st_bits,
    input  logic                crc6_force,
    input  logic [MT_MAX_W-1:0] mt,
    input  logic [ST_MAX_W-1:0] st,
    input  logic                e_amp,
    input  logic                e_freq,
    output logic [PL_MAX_W-1:0] word,
    output logic [LEN_W-1:0]    len,
    output logic                use6
);

    logic [4:0]          mtw;
    logic [3:0]          stw;
    logic [3:0]          st_shift;
    logic [MT_MAX_W-1:0] mt_f;
    logic [ST_MAX_W-1:0] st_f;

    // Field widths, masking of the multiturn count and alignment of the angle.
    always_comb begin
        mtw      = mt_width(mt_code);
        stw      = st_width(st_bits);
        st_shift = 4'(ST_MAX_W) - stw;
        for (int i = 0; i < MT_MAX_W; i++)
            mt_f[i] = (i < int'(mtw)) ? mt[i] : 1'b0;
        st_f = st >> st_shift;
    end

    // Concatenate the fields: multiturn high, angle, then the two error bits.
    always_comb begin
        word = ({{(PL_MAX_W-MT_MAX_W){1'b0}}, mt_f} << (5'(stw) + 5'd2))
             | ({{(PL_MAX_W-ST_MAX_W){1'b0}}, st_f} << 2)
             | {{(PL_MAX_W-2){1'b0}}, e_amp, e_freq};
        len  = LEN_W'(mtw) + LEN_W'(stw) + LEN_W'(2);
        use6 = crc6_force | mt_code[1];
    end

endmodule

// File: rtl/biss_crc_ser.sv
// Serial CRC generator, MSB first, zero start value.
// Runs either the 5-bit or the 6-bit polynomial in one 6-bit register; in
// 5-bit mode the top bit is kept at zero. Assumes use6 does not change
// between a clear and the last data bit.
module biss_crc_ser
    import biss_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 din,
    input  logic                 use6,
    output logic [CRC_MAX_W-1:0] crc
);

    logic                 fb;
    logic [CRC_MAX_W-1:0] nxt;

    // Next remainder for one input bit.
    always_comb begin
        fb  = din ^ (use6 ? crc[5] : crc[4]);
        nxt = {crc[4:0], 1'b0};
        if (!use6)
            nxt[5] = 1'b0;
        if (fb)
            nxt = nxt ^ (use6 ? TAPS_CRC6 : TAPS_CRC5);
    end

    // Remainder register: cleared at capture, stepped once per payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc <= '0;
        else if (en)
            crc <= nxt;
    end

    a_r8_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0));

    a_r7_crc5_top_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !use6) |=> !crc[5]);

endmodule

// File: rtl/biss_tmo_timer.sv
// End-of-frame timeout down-counter.
// A load sets the counter to one less than the requested length; it then
// counts down to zero and rests there. Assumes load_val is at least 1.
module biss_tmo_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load or decrement the remaining timeout length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r9_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/biss_pos_tx.sv
// Position frame transmitter, slave side.
// Captures a position snapshot on the master's first falling clock edge, then
// sends preamble, payload and inverted CRC (or payload only in SSI mode) on
// later rising edges, and ends with a line-low timeout. Assumes master clock
// edges are spaced by more than three clk cycles.
module biss_pos_tx
    import biss_tx_pkg::*;
#(
    parameter int PER_W    = 8,
    parameter int TO_LONG  = 46,
    parameter int TO_SHORT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ma,
    input  logic [MT_MAX_W-1:0] pos_mt,
    input  logic [ST_MAX_W-1:0] pos_st,
    input  logic                err_amp,
    input  logic                err_freq,
    input  logic [1:0]          cfg_mt_len,
    input  logic [3:0]          cfg_st_bits,
    input  logic                cfg_crc6,
    input  logic                cfg_short_tmo,
    input  logic                cfg_adapt_tmo,
    input  logic                cfg_ssi,
    output logic                slo
);

    localparam logic [PER_W-1:0] TMO_L = PER_W'(TO_LONG);
    localparam logic [PER_W-1:0] TMO_S = PER_W'(TO_SHORT);

    tx_state_t state;

    logic ma_rise, ma_fall;
    logic [PER_W-1:0] period_now;

    logic [MT_MAX_W-1:0] snap_mt;
    logic [ST_MAX_W-1:0] snap_st;
    logic                snap_amp, snap_freq;
    logic [1:0]          l_mt_len;
    logic [3:0]          l_st_bits;
    logic                l_crc6, l_short, l_adapt, l_ssi;

    logic [PL_MAX_W-1:0]  word;
    logic [LEN_W-1:0]     len;
    logic                 use6;
    logic [CRC_MAX_W-1:0] crc;

    logic [LEN_W-1:0] idx;
    logic             done;
    logic             hdr_first;

    logic             capture;
    logic             crc_en;
    logic             crc_din;
    logic             tmo_load;
    logic [PER_W-1:0] tmo_val;
    logic             tmo_zero;

    biss_ma_sync #(.PER_W(PER_W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ma_in      (ma),
        .ma_rise    (ma_rise),
        .ma_fall    (ma_fall),
        .period_now (period_now)
    );

    biss_payload_fmt u_fmt (
        .mt_code    (l_mt_len),
        .st_bits    (l_st_bits),
        .crc6_force (l_crc6),
        .mt         (snap_mt),
        .st         (snap_st),
        .e_amp      (snap_amp),
        .e_freq     (snap_freq),
        .word       (word),
        .len        (len),
        .use6       (use6)
    );

    biss_crc_ser u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (capture),
        .en    (crc_en),
        .din   (crc_din),
        .use6  (use6),
        .crc   (crc)
    );

    biss_tmo_timer #(.CNT_W(PER_W)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmo_load),
        .load_val (tmo_val),
        .zero     (tmo_zero)
    );

    // Event decode: capture, CRC stepping and timeout start.
    always_comb begin
        capture  = (state == TX_IDLE) && ma_fall;
        crc_din  = word[idx];
        crc_en   = ma_rise && (state == TX_DATA) && !done;
        tmo_load = ma_rise && done &&
                   ((state == TX_CRC) || (state == TX_DATA && l_ssi));
        if (l_adapt)
            tmo_val = period_now;
        else
            tmo_val = l_short ? TMO_S : TMO_L;
    end

    // Snapshot of position, flags and configuration at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_mt   <= '0;
            snap_st   <= '0;
            snap_amp  <= 1'b0;
            snap_freq <= 1'b0;
            l_mt_len  <= '0;
            l_st_bits <= '0;
            l_crc6    <= 1'b0;
            l_short   <= 1'b0;
            l_adapt   <= 1'b0;
            l_ssi     <= 1'b0;
        end else if (capture) begin
            snap_mt   <= pos_mt;
            snap_st   <= pos_st;
            snap_amp  <= err_amp;
            snap_freq <= err_freq;
            l_mt_len  <= cfg_mt_len;
            l_st_bits <= cfg_st_bits;
            l_crc6    <= cfg_crc6;
            l_short   <= cfg_short_tmo;
            l_adapt   <= cfg_adapt_tmo;
            l_ssi     <= cfg_ssi;
        end
    end

    // Frame sequencer and line driver, one bit per synchronized rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            slo       <= 1'b1;
            idx       <= '0;
            done      <= 1'b0;
            hdr_first <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    slo <= 1'b1;
                    if (ma_fall)
                        state <= TX_WAIT;
                end
                TX_WAIT: begin
                    if (ma_rise) begin
                        if (l_ssi) begin
                            slo   <= word[len - 1'b1];
                            idx   <= len - LEN_W'(2);
                            done  <= 1'b0;
                            state <= TX_DATA;
                        end else begin
                            slo       <= 1'b0;
                            hdr_first <= 1'b1;
                            state     <= TX_HDR;
                        end
                    end
                end
                TX_HDR: begin
                    if (ma_rise) begin
                        if (hdr_first) begin
                            slo       <= 1'b1;
                            hdr_first <= 1'b0;
                        end else begin
                            slo   <= 1'b0;
                            idx   <= len - 1'b1;
                            done  <= 1'b0;
                            state <= TX_DATA;
                        end
                    end
                end
                TX_DATA: begin
                    if (ma_rise) begin
                        if (!done) begin
                            slo <= word[idx];
                            if (idx == '0)
                                done <= 1'b1;
                            else
                                idx <= idx - 1'b1;
                        end else if (l_ssi) begin
                            slo   <= 1'b0;
                            state <= TX_TMO;
                        end else begin
                            slo   <= ~(use6 ? crc[5] : crc[4]);
                            idx   <= use6 ? LEN_W'(4) : LEN_W'(3);
                            done  <= 1'b0;
                            state <= TX_CRC;
                        end
                    end
                end
                TX_CRC: begin
                    if (ma_rise) begin
                        if (!done) begin
                            slo <= ~crc[idx[2:0]];
                            if (idx == '0)
                                done <= 1'b1;
                            else
                                idx <= idx - 1'b1;
                        end else begin
                            slo   <= 1'b0;
                            state <= TX_TMO;
                        end
                    end
                end
                TX_TMO: begin
                    if (tmo_zero) begin
                        slo   <= 1'b1;
                        state <= TX_IDLE;
                    end
                end
                default: begin
                    slo   <= 1'b1;
                    state <= TX_IDLE;
                end
            endcase
        end
    end

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE || state == TX_WAIT) |-> slo);

    a_r9_low_during_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_TMO) |-> !slo);

    a_r11_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_TMO && !tmo_zero) |=> (state == TX_TMO));

    a_r2_snapshot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && $past(state) != TX_IDLE) |->
            ($stable(snap_mt) && $stable(snap_st) && $stable(l_mt_len)));

    a_r12_ssi_skips_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ssi && state != TX_IDLE) |-> (state != TX_HDR && state != TX_CRC));

    a_r6_length_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE) |->
            (len >= LEN_W'(ST_MIN_W + 2) && len <= LEN_W'(PL_MAX_W)));

endmodule

// File: tb/sim_biss_pos_tx.sv
// Bench for the position frame transmitter: directed corners plus seeded
// random frames, each bit compared with a frame model built from the
// requirements.
module sim_biss_pos_tx;
    timeunit 1ns;
    timeprecision 1ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ma = 1'b1;
    logic [23:0] pos_mt = '0;
    logic [12:0] pos_st = '0;
    logic        err_amp = 1'b0, err_freq = 1'b0;
    logic [1:0]  cfg_mt_len = '0;
    logic [3:0]  cfg_st_bits = 4'd13;
    logic        cfg_crc6 = 1'b0, cfg_short_tmo = 1'b0;
    logic        cfg_adapt_tmo = 1'b0, cfg_ssi = 1'b0;
    logic        slo;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic  exp_bit [0:79];
    string exp_tag [0:79];
    int    exp_n;

    always #10 clk = ~clk;

    biss_pos_tx u0 (
        .clk(clk), .rst_n(rst_n), .ma(ma),
        .pos_mt(pos_mt), .pos_st(pos_st),
        .err_amp(err_amp), .err_freq(err_freq),
        .cfg_mt_len(cfg_mt_len), .cfg_st_bits(cfg_st_bits),
        .cfg_crc6(cfg_crc6), .cfg_short_tmo(cfg_short_tmo),
        .cfg_adapt_tmo(cfg_adapt_tmo), .cfg_ssi(cfg_ssi),
        .slo(slo)
    );

    function automatic int mtw_of(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 8;
            2'd2: return 12;
            default: return 24;
        endcase
    endfunction

    function automatic int stw_of(input logic [3:0] b);
        if (b < 3) return 3;
        if (b > 13) return 13;
        return int'(b);
    endfunction

    task automatic push(input logic b, input string t);
        exp_bit[exp_n] = b;
        exp_tag[exp_n] = t;
        exp_n++;
    endtask

    // Expected line bits for the present inputs (R3, R4, R5, R6, R7, R8, R12).
    task automatic build_frame();
        int         mw, sw, cw, p0;
        logic [5:0] r, taps;
        logic       fb;
        exp_n = 0;
        mw = mtw_of(cfg_mt_len);
        sw = stw_of(cfg_st_bits);
        if (!cfg_ssi) begin
            push(1'b0, "R3 ack");
            push(1'b1, "R3 start");
            push(1'b0, "R3 control");
        end
        p0 = exp_n;
        for (int i = mw - 1; i >= 0; i--)
            push(pos_mt[i], cfg_ssi ? "R12 R5 R2 multiturn" : "R5 R2 multiturn");
        for (int i = 12; i >= 13 - sw; i--)
            push(pos_st[i], cfg_ssi ? "R12 R6 R2 angle" : "R6 R2 angle");
        push(err_amp, "R4 R2 amplitude flag");
        push(err_freq, "R4 R2 frequency flag");
        if (!cfg_ssi) begin
            cw   = (cfg_crc6 || cfg_mt_len[1]) ? 6 : 5;
            taps = (cw == 6) ? 6'h03 : 6'h05;
            r    = '0;
            for (int k = p0; k < exp_n; k++) begin
                fb = exp_bit[k] ^ r[cw-1];
                r  = r << 1;
                if (cw == 5) r[5] = 1'b0;
                if (fb) r = r ^ taps;
            end
            for (int i = cw - 1; i >= 0; i--)
                push(~r[i], "R7 R8 crc");
        end
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: slo=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] code, input logic [3:0] sb,
                             input logic c6, input logic ssi, input logic sh,
                             input logic ad, input int h, input bit poke);
        int cnt, exp_t;
        @(negedge clk);
        cfg_mt_len = code; cfg_st_bits = sb; cfg_crc6 = c6; cfg_ssi = ssi;
        cfg_short_tmo = sh; cfg_adapt_tmo = ad;
        pos_mt = 24'($urandom); pos_st = 13'($urandom);
        err_amp = 1'($urandom); err_freq = 1'($urandom);
        build_frame();
        @(negedge clk);
        check(slo, 1'b1, "R1 idle before frame");
        ma = 1'b0;
        repeat (3) @(negedge clk);
        // R2: scramble every input after the capture
        pos_mt = ~pos_mt; pos_st = ~pos_st; err_amp = ~err_amp; err_freq = ~err_freq;
        cfg_mt_len = ~cfg_mt_len; cfg_st_bits = ~cfg_st_bits; cfg_crc6 = ~cfg_crc6;
        cfg_ssi = ~cfg_ssi; cfg_short_tmo = ~cfg_short_tmo; cfg_adapt_tmo = ~cfg_adapt_tmo;
        repeat (h - 3) @(negedge clk);
        for (int b = 0; b < exp_n; b++) begin
            ma = 1'b1;
            repeat (3) @(negedge clk);
            check(slo, exp_bit[b], exp_tag[b]);
            repeat (h - 3) @(negedge clk);
            ma = 1'b0;
            repeat (h) @(negedge clk);
        end
        ma = 1'b1;
        exp_t = ad ? 2 * h : (sh ? 3 : 46);
        cnt = 0;
        while (cnt < 600) begin
            @(negedge clk);
            cnt++;
            if (cnt >= 3 && slo) break;
            if (poke && cnt == 8) ma = 1'b0;
            if (poke && cnt == 14) ma = 1'b1;
        end
        n_vec++;
        if (cnt != exp_t + 3) begin
            n_bad++;
            $display("FAIL %s: release after %0d cycles expected %0d",
                     ad ? "R10 adaptive timeout" : (poke ? "R11 R9 timeout" : "R9 timeout"),
                     cnt, exp_t + 3);
        end
        repeat (2 * h + 4) @(negedge clk);
        check(slo, 1'b1, "R11 R1 idle after timeout");
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        check(slo, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(slo, 1'b1, "R1 after reset");
        // directed corners
        run_frame(2'd0, 4'd3,  1'b0, 1'b0, 1'b1, 1'b0, 4, 1'b0); // shortest BiSS frame, R9 short
        run_frame(2'd3, 4'd13, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0); // longest frame, R9 long
        run_frame(2'd1, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 5, 1'b0); // R6 clamp low, CRC5
        run_frame(2'd2, 4'd15, 1'b0, 1'b0, 1'b1, 1'b0, 4, 1'b0); // R6 clamp high, CRC6
        run_frame(2'd1, 4'd10, 1'b1, 1'b0, 1'b1, 1'b0, 4, 1'b0); // R7 forced CRC6
        run_frame(2'd0, 4'd7,  1'b1, 1'b0, 1'b1, 1'b0, 4, 1'b0); // R7 forced CRC6, no multiturn
        run_frame(2'd2, 4'd9,  1'b0, 1'b1, 1'b1, 1'b0, 4, 1'b0); // R12 SSI
        run_frame(2'd0, 4'd3,  1'b0, 1'b1, 1'b0, 1'b0, 6, 1'b0); // R12 SSI minimal
        run_frame(2'd1, 4'd12, 1'b0, 1'b0, 1'b0, 1'b1, 4, 1'b0); // R10 period 8
        run_frame(2'd3, 4'd5,  1'b0, 1'b1, 1'b0, 1'b1, 6, 1'b0); // R10 period 12 in SSI
        run_frame(2'd2, 4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b1); // R11 pulse during timeout
        // seeded random frames
        for (int k = 0; k < 24; k++)
            run_frame(2'($urandom), 4'($urandom), 1'(($urandom % 4) == 0),
                      1'(($urandom % 5) == 0), 1'($urandom),
                      1'(($urandom % 4) == 0), 4 + int'($urandom % 3), 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule